// File: doc/BRIEF.md
# Dual-Comparator Compare-Match Timer

This block is an up-counting timer with two comparators and one output pin. The counter is 10 bits wide and advances once per clock while the timer runs. A coarse period comparator looks only at the upper three counter bits. A fine comparator looks at the full count. Either comparator can be chosen as the source that returns the counter to zero. Each comparator raises a one-cycle request flag when it matches. The output pin reacts only to fine-comparator matches.

The block is configured through plain input pins: run, pause, clear source, a two-bit output action, an initial level, a polarity and the two compare values. The configuration is expected to stay fixed while the timer runs. Starting the timer (a low-to-high change of `run`) sets the counter to zero and returns the pin to its initial level. Dropping `run` or raising `hold` freezes the count.

Top module: `cmp_match_timer`

## Requirements
- R1: During and after synchronous reset (`rst_n` low at a clock edge), `count` is 0, both flags are low and the internal pin level is 0, so `pin_out` equals `pol`.
- R2: On the clock edge where `run` is first seen high after being low, `count` becomes 0 and the pin level takes `init_lvl`, so `pin_out` = `init_lvl` XOR `pol`. On each later edge with `run` high and `hold` low, `count` advances by one.
- R3: On an edge where `run` is low, or `hold` is high (and it is not a start edge), `count` keeps its value. Counting resumes from that value when `hold` falls.
- R4: With `clr_sel` = 0 and `per_val` = P not 0, the period match occurs on the advancing edge where `count` equals P×128 (P in bits [9:7], lower bits zero). At that edge `count` goes to 0, and `flag_p` is high for exactly the one following cycle.
- R5: With `clr_sel` = 0 and `per_val` = 0, the counter runs to 0x3FF and wraps to 0. `flag_p` pulses for one cycle on that wrap.
- R6: The fine match occurs on an advancing edge where `count` equals the effective fine value. `flag_a` is then high for exactly the following cycle. With `clr_sel` = 0 this match does not clear the counter.
- R7: With `clr_sel` = 1, a fine match returns `count` to 0 and `flag_p` never rises, whatever `per_val` is.
- R8: A `cmp_val` of 0 is unsupported. `cfg_err` is high while `cmp_val` is 0, and the block then uses 1 as the fine value.
- R9: On a fine match, `act_sel` sets the pin level for the next cycle: 00 keeps it, 01 makes it 0, 10 makes it 1, 11 inverts it. `pin_out` is always the level XOR `pol`.
- R10: The pin level changes only on a fine match or a start edge. Period matches never move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Timer enable; a rising edge restarts the timer |
| hold | input | 1 | Pause; freezes the count |
| clr_sel | input | 1 | Clear source: 0 = period comparator, 1 = fine comparator |
| act_sel | input | 2 | Pin action on a fine match |
| init_lvl | input | 1 | Pin level loaded at start |
| pol | input | 1 | Inverts the pin when 1 |
| per_val | input | 3 | Period value, compared with count bits [9:7] |
| cmp_val | input | 10 | Fine compare value |
| count | output | 10 | Current counter value |
| flag_p | output | 1 | One-cycle period-match request |
| flag_a | output | 1 | One-cycle fine-match request |
| pin_out | output | 1 | Timer output pin |
| cfg_err | output | 1 | High while `cmp_val` is 0 |

## Verification
The assertions assume that `clr_sel`, `per_val` and `cmp_val` stay fixed whenever the counter is advancing. Under that assumption a match cannot repeat on consecutive cycles, and a period flag always follows a cycle in which the period comparator was the clear source. The random stimulus changes configuration only while `run` is low, before each restart. The directed cases edit the fine value only at a point where the count is below both the old and the new value. `hold` pulses and short `run` drops are scattered through every run, so that freezes and restarts land at arbitrary counts.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the compare-match timer.
// Assumes: nothing beyond being compiled before the timer modules.
package cmp_timer_pkg;

    // Pin action applied on a fine-comparator match.
    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_FLIP = 2'b11
    } act_e;

endpackage

// File: rtl/cmp_timer_counter.sv
`timescale 1ns/1ps
// Module: cmp_timer_counter
// Holds the up-counter and the run-edge detector. It restarts on a run
// rising edge, advances while running and not held, and goes to zero when
// the match unit requests a clear.
// Assumes: clr_now is only asserted in a cycle where adv is high.
module cmp_timer_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic             clr_now,
    output logic [CNT_W-1:0] cnt,
    output logic             start,
    output logic             adv
);

    logic run_q;

    // Start pulse and advance qualifier derived from run history.
    always_comb begin
        start = run && !run_q;
        adv   = run && run_q && !hold;
    end

    // Remember run from the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    // Counter register: restart, clear on match, or increment with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (start)   cnt <= '0;
        else if (adv)     cnt <= clr_now ? '0 : cnt + 1'b1;
    end

    assert_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    assert_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start) |=> $stable(cnt));

endmodule

// File: rtl/cmp_timer_match.sv
`timescale 1ns/1ps
// Module: cmp_timer_match
// Compares the count with the coarse period value (upper bits) and the fine
// value, chooses the clear source and registers the one-cycle request flags.
// Assumes: configuration inputs stay fixed while adv is high.
module cmp_timer_match #(
    parameter int CNT_W = 10,
    parameter int PER_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             adv,
    input  logic             clr_sel,
    input  logic [PER_W-1:0] per_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             a_hit,
    output logic             clr_now,
    output logic             flag_a,
    output logic             flag_p,
    output logic             cfg_err
);

    localparam int SHIFT = CNT_W - PER_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] a_eff;
    logic [CNT_W-1:0] p_tgt;
    logic             per_zero;
    logic             p_hit;

    // Clamp an illegal zero fine value to one and report it.
    always_comb begin
        cfg_err = (cmp_val == '0);
        a_eff   = cfg_err ? ONE : cmp_val;
    end

    // Period target: the period value placed in the top bits.
    always_comb begin
        per_zero = (per_val == '0);
        p_tgt    = per_zero ? CNT_MAX : {per_val, {SHIFT{1'b0}}};
    end

    // Match detection, only on edges where the counter advances.
    always_comb begin
        a_hit = adv && (cnt == a_eff);
        p_hit = adv && (cnt == p_tgt);
    end

    // Clear source selection; a zero period lets the counter wrap by itself.
    always_comb begin
        if (clr_sel) clr_now = a_hit;
        else         clr_now = p_hit && !per_zero;
    end

    // Register the request flags; the period flag is dropped when the fine
    // comparator owns the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_a <= 1'b0;
            flag_p <= 1'b0;
        end else begin
            flag_a <= a_hit;
            flag_p <= p_hit && !clr_sel;
        end
    end

    assert_no_pflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_p |-> $past(!clr_sel));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (cnt == '0));

    assert_single_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && $stable(cmp_val)) |-> !a_hit || (cnt != a_eff));

endmodule

// File: rtl/cmp_timer_outpin.sv
`timescale 1ns/1ps
// Module: cmp_timer_outpin
// Keeps the pin level, loads the initial level at start and applies the
// selected action on each fine match. The polarity is applied at the port.
// Assumes: start and a_hit are never high in the same cycle.
module cmp_timer_outpin
    import cmp_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       a_hit,
    input  logic [1:0] act_sel,
    input  logic       init_lvl,
    input  logic       pol,
    output logic       pin_out
);

    logic lvl;
    logic lvl_nxt;

    // Next level chosen by the action field on a fine match.
    always_comb begin
        lvl_nxt = lvl;
        case (act_e'(act_sel))
            ACT_KEEP: lvl_nxt = lvl;
            ACT_LOW:  lvl_nxt = 1'b0;
            ACT_HIGH: lvl_nxt = 1'b1;
            ACT_FLIP: lvl_nxt = !lvl;
            default:  lvl_nxt = lvl;
        endcase
    end

    // Level register: initial level at start, action on fine match.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl <= 1'b0;
        else if (start)  lvl <= init_lvl;
        else if (a_hit)  lvl <= lvl_nxt;
    end

    // Apply polarity on the way to the pin.
    always_comb pin_out = lvl ^ pol;

    assert_pin_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_hit && !start) |=> $stable(lvl));

    assert_drive_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && !start && act_sel == 2'b10) |=> lvl);

    assert_start_lvl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (lvl == $past(init_lvl)));

endmodule

// File: rtl/cmp_match_timer.sv
`timescale 1ns/1ps
// Module: cmp_match_timer (top)
// Compare-match timer: counter, two comparators with selectable clear
// source, one-cycle request flags and a fine-match-driven output pin.
// Assumes: configuration is changed only while run is low.
module cmp_match_timer #(
    parameter int CNT_W = 10,
    parameter int PER_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic             clr_sel,
    input  logic [1:0]       act_sel,
    input  logic             init_lvl,
    input  logic             pol,
    input  logic [PER_W-1:0] per_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             flag_p,
    output logic             flag_a,
    output logic             pin_out,
    output logic             cfg_err
);

    logic start;
    logic adv;
    logic a_hit;
    logic clr_now;

    cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .hold    (hold),
        .clr_now (clr_now),
        .cnt     (count),
        .start   (start),
        .adv     (adv)
    );

    cmp_timer_match #(.CNT_W(CNT_W), .PER_W(PER_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (count),
        .adv     (adv),
        .clr_sel (clr_sel),
        .per_val (per_val),
        .cmp_val (cmp_val),
        .a_hit   (a_hit),
        .clr_now (clr_now),
        .flag_a  (flag_a),
        .flag_p  (flag_p),
        .cfg_err (cfg_err)
    );

    cmp_timer_outpin u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .a_hit    (a_hit),
        .act_sel  (act_sel),
        .init_lvl (init_lvl),
        .pol      (pol),
        .pin_out  (pin_out)
    );

endmodule

// File: tb/cmp_match_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_match_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, hold = 1'b0, clr_sel = 1'b0, init_lvl = 1'b0, pol = 1'b0;
    logic [1:0] act_sel = 2'b00;
    logic [2:0] per_val = 3'd0;
    logic [9:0] cmp_val = 10'd1;
    logic [9:0] count;
    logic       flag_p, flag_a, pin_out, cfg_err;

    always #4 clk = ~clk;

    cmp_match_timer dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .hold(hold), .clr_sel(clr_sel),
        .act_sel(act_sel), .init_lvl(init_lvl), .pol(pol), .per_val(per_val),
        .cmp_val(cmp_val), .count(count), .flag_p(flag_p), .flag_a(flag_a),
        .pin_out(pin_out), .cfg_err(cfg_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(string rq, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", rq, got, exp);
        end
    endtask

    // Behavioural reference written from the requirements.
    logic [9:0] m_cnt;
    logic       m_runq, m_lvl, m_fa, m_fp;

    function automatic logic [9:0] fine_of(logic [9:0] v);
        return (v == 10'd0) ? 10'd1 : v;
    endfunction

    function automatic logic [9:0] period_of(logic [2:0] p);
        return (p == 3'd0) ? 10'h3FF : {p, 7'd0};
    endfunction

    function automatic logic act_level(logic [1:0] a, logic cur);
        case (a)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return !cur;
            default: return cur;
        endcase
    endfunction

    always @(posedge clk) begin : ref_model
        logic st, ad, ah, ph, cl;
        if (!rst_n) begin
            m_cnt <= '0; m_runq <= 1'b0; m_lvl <= 1'b0; m_fa <= 1'b0; m_fp <= 1'b0;
        end else begin
            st = run && !m_runq;
            ad = run && m_runq && !hold;
            ah = ad && (m_cnt == fine_of(cmp_val));
            ph = ad && (m_cnt == period_of(per_val));
            cl = clr_sel ? ah : (ph && per_val != 3'd0);
            m_runq <= run;
            m_fa   <= ah;
            m_fp   <= ph && !clr_sel;
            if (st)      m_cnt <= '0;
            else if (ad) m_cnt <= cl ? 10'd0 : m_cnt + 10'd1;
            if (st)      m_lvl <= init_lvl;
            else if (ah) m_lvl <= act_level(act_sel, m_lvl);
        end
    end

    // Cycle-by-cycle comparison against the reference, mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 R3 R4 count vs model", count, m_cnt);
            chk("R4 R5 R7 flag_p vs model", flag_p, m_fp);
            chk("R6 flag_a vs model", flag_a, m_fa);
            chk("R9 pin_out vs model", pin_out, m_lvl ^ pol);
            chk("R8 cfg_err vs model", cfg_err, cmp_val == 10'd0);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_cnt(int v);
        for (int i = 0; i < 2100 && count != v; i++) step(1);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL R2 watchdog: got hung expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        step(3);
        chk("R1 count in reset", count, 0);
        chk("R1 flag_p in reset", flag_p, 0);
        chk("R1 flag_a in reset", flag_a, 0);
        chk("R1 pin in reset", pin_out, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 count after reset", count, 0);

        // Period clear with toggle action
        per_val = 3'd1; clr_sel = 1'b0; cmp_val = 10'd5; act_sel = 2'b11;
        init_lvl = 1'b0; pol = 1'b0; run = 1'b1;
        step(1);
        chk("R2 count at start", count, 0);
        chk("R2 pin at start", pin_out, 0);
        step(1);
        chk("R2 count advances", count, 1);
        wait_cnt(5); step(1);
        chk("R6 flag_a after fine match", flag_a, 1);
        chk("R6 no clear on fine match", count, 6);
        chk("R9 toggle on fine match", pin_out, 1);
        wait_cnt(128); step(1);
        chk("R4 count cleared by period", count, 0);
        chk("R4 flag_p pulse", flag_p, 1);
        chk("R10 period match leaves pin", pin_out, 1);
        step(1);
        chk("R4 flag_p one cycle", flag_p, 0);

        // Pause and stop
        wait_cnt(20);
        hold = 1'b1; step(5);
        chk("R3 frozen under hold", count, 20);
        hold = 1'b0; step(1);
        chk("R3 resumes after hold", count, 21);
        run = 1'b0; step(4);
        chk("R3 frozen when stopped", count, 21);

        // Fine clear with illegal zero value, drive-high action, inverted pin
        clr_sel = 1'b1; cmp_val = 10'd0; act_sel = 2'b10; pol = 1'b1; init_lvl = 1'b0;
        #1;
        chk("R8 cfg_err on zero value", cfg_err, 1);
        run = 1'b1;
        step(1);
        chk("R2 initial level with polarity", pin_out, 1);
        step(1);
        chk("R8 count reaches clamped value", count, 1);
        step(1);
        chk("R8 R7 cleared at clamped value", count, 0);
        chk("R7 flag_a on fine clear", flag_a, 1);
        chk("R9 drive high inverted", pin_out, 0);
        cmp_val = 10'd300;
        begin
            int seen = 0;
            for (int i = 0; i < 1200; i++) begin
                step(1);
                if (flag_p) seen++;
            end
            chk("R7 no period flag under fine clear", seen, 0);
        end

        // Full overflow wrap
        run = 1'b0; step(1);
        clr_sel = 1'b0; per_val = 3'd0; cmp_val = 10'd1000; act_sel = 2'b01; run = 1'b1;
        step(1);
        wait_cnt(1023); step(1);
        chk("R5 wrap to zero", count, 0);
        chk("R5 flag_p on wrap", flag_p, 1);

        // Random segments; configuration changes only while stopped
        for (int s = 0; s < 40; s++) begin
            int len;
            run = 1'b0; hold = 1'b0;
            step(1);
            per_val  = 3'($urandom_range(0, 7));
            clr_sel  = 1'($urandom_range(0, 1));
            act_sel  = 2'($urandom_range(0, 3));
            init_lvl = 1'($urandom_range(0, 1));
            pol      = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) cmp_val = 10'd0;
            else cmp_val = 10'($urandom_range(1, (per_val == 0) ? 1023 : per_val * 128 + 20));
            run = 1'b1;
            len = $urandom_range(300, 1500);
            for (int i = 0; i < len; i++) begin
                hold = ($urandom_range(0, 19) == 0);
                if ($urandom_range(0, 299) == 0) begin
                    run = 1'b0; step(1); run = 1'b1;
                end
                step(1);
            end
        end

        hold = 1'b0;
        step(2);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule